// File: doc/BRIEF.md
# Two-Wire Configuration Programmer and Verifier

This block is the host-side sequencer that writes a fixed-size configuration image into a serially programmed target and then reads it back to verify it. The target is reached over two lines: a clock line that this block always drives, and a bidirectional data line. The data line is driven through `dataOut` while `dataOe` is high, and it is read back through `dataIn`. The image is 192 bits wide and is presented on a parallel input. It is captured when a session starts.

A session has four stages. First the block enters program mode. Next it sends each 16-bit word of the image, least significant bit first, and follows each word with its bitwise complement. After every word pair it releases the data line, waits a fixed programming delay and then polls for an acknowledge. Finally, with no new entry sequence, it clocks the whole image back in and compares it bit by bit. All times are counted in system clock cycles and set by parameters. The defaults are short and suit simulation. A real target needs values scaled from milliseconds and microseconds.

The status outputs are `done`, an acknowledge-timeout error, a verify-mismatch flag and the index of the first bit that failed. They hold their values until the next start.

Top module: `cfg_prog_master`

## Requirements
- R1: After an accepted start, the block drives the clock high and the data line low (`dataOe`=1) for exactly HOLD_CYC cycles. It then drives the data line high for GAP_CYC cycles while the clock stays high, and only then sends the first bit.
- R2: The image is sent as N_WORDS words of WORD_W bits. Word w is `image[w*WORD_W +: WORD_W]`, words go in ascending order, and bits go least significant first. The target samples each bit on the falling clock edge.
- R3: Each word is followed directly by WORD_W bits of its bitwise complement, also least significant first.
- R4: During a transfer, every clock high phase lasts exactly HALF_CYC cycles and every low phase lasts at least HALF_CYC cycles. The driven data value does not change while the clock is low.
- R5: After the last complement bit, the block holds the clock low, releases the data line (`dataOe`=0) and waits WRITE_CYC cycles. It then polls `dataIn` for a high acknowledge. If the target raises the acknowledge D cycles after the falling edge of the last bit, the clock stays low for max(HALF_CYC+WRITE_CYC, D)+1 cycles before the next rising edge.
- R6: If no acknowledge arrives within ACK_TO_CYC polling cycles, the session ends at once. `ackErr`=1, `done`=0, both lines are idle, and no verify is run.
- R7: The verify stage starts right after the last word is acknowledged, with the same low-gap rule as R5 and no new entry sequence. It gives IMG_W clock pulses with the data line released and samples `dataIn` in the last cycle of each high phase. Bit i is compared with `image[i]`.
- R8: `verifyErr` is set if any read bit differs from the captured image. `mismatchIdx` holds the lowest differing index, and it reads 0 when there is no mismatch.
- R9: `busy` rises in the cycle after an accepted start and falls when the session ends. The session ends with exactly one of `done` (the full sequence ran) or `ackErr`. A start clears all status outputs.
- R10: A start pulse while `busy` is high is ignored. Changes on `image` after the start have no effect on the words sent or compared.
- R11: While reset is held, `progClk`, `dataOe`, `dataOut`, `busy`, `done`, `ackErr`, `verifyErr` and `mismatchIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a session |
| image | input | WORD_W*N_WORDS | Configuration image, captured at start |
| dataIn | input | 1 | Data line as read back from the target |
| progClk | output | 1 | Clock line to the target |
| dataOut | output | 1 | Value driven on the data line |
| dataOe | output | 1 | Drive enable for the data line |
| busy | output | 1 | High for the duration of a session |
| done | output | 1 | Session ran through verify |
| ackErr | output | 1 | Session aborted on acknowledge timeout |
| verifyErr | output | 1 | Read-back differed from the image |
| mismatchIdx | output | $clog2(WORD_W*N_WORDS) | Index of the first mismatching bit |

## Verification
Most faults in the phase counter or the sequencer state show up as an error in a measured length on the clock line. The entry hold, a high phase or the low gap before the next word would come out wrong within one word time. A slip in the bit counter or the word selector is visible at the pair boundary. There the target model sees a word whose complement does not match, or a word in the wrong position, so the error appears within 32 bit periods. A fault in the read-back index or the first-mismatch latch only shows when the session ends. The bench therefore places corrupted bits at the first and last indices and puts two corruptions in one image.

// File: rtl/cfg_prog_pkg.sv
package cfg_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENT_HOLD,
    ST_ENT_GAP,
    ST_TX_HI,
    ST_TX_LO,
    ST_WR_WAIT,
    ST_ACK_POLL,
    ST_VF_HI,
    ST_VF_LO
  } seqState_e;

  typedef enum logic [1:0] {
    LINE_LOW,
    LINE_HIGH,
    LINE_BIT
  } lineMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;      // capture image, clear status and indices
    logic loadWord;   // load word pair into the shifter
    logic advWord;    // with loadWord: move to the next word first
    logic shiftBit;   // present the next bit of the pair
    logic sampleBit;  // compare one read-back bit
    logic setDone;
    logic setAckErr;
  } seqStrobe_t;

endpackage

// File: rtl/cfg_prog_timer.sv
module cfg_prog_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             zero
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/cfg_prog_ctrl.sv
module cfg_prog_ctrl
  import cfg_prog_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int HOLD_CYC   = 20,
  parameter int GAP_CYC    = 4,
  parameter int HALF_CYC   = 3,
  parameter int WRITE_CYC  = 10,
  parameter int ACK_TO_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       ackIn,
  input  logic       lastWord,
  input  logic       lastBit,
  output logic       progClk,
  output logic       dataOe,
  output lineMode_e  lineMode,
  output logic       busy,
  output seqStrobe_t stb
);

  localparam int PAIR_BITS = 2 * WORD_W;
  localparam int BIT_W     = $clog2(PAIR_BITS);
  localparam int MAX_A     = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int MAX_B     = (HALF_CYC > WRITE_CYC) ? HALF_CYC : WRITE_CYC;
  localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC   = (MAX_C > ACK_TO_CYC) ? MAX_C : ACK_TO_CYC;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);

  localparam logic [TMR_W-1:0] HOLD_LD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD   = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] HALF_LD  = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] WRITE_LD = TMR_W'(WRITE_CYC - 1);
  localparam logic [TMR_W-1:0] ACK_LD   = TMR_W'(ACK_TO_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PAIR_BITS - 1);

  seqState_e        state, stateNxt;
  logic             tLoad, tZero;
  logic [TMR_W-1:0] tVal;
  logic [BIT_W-1:0] bitCnt;
  logic             bitClr, bitInc;

  cfg_prog_timer #(.CNT_W(TMR_W)) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .load   (tLoad),
    .loadVal(tVal),
    .zero   (tZero)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (bitClr)      bitCnt <= '0;
      else if (bitInc) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stateNxt = state;
    tLoad    = 1'b0;
    tVal     = '0;
    bitClr   = 1'b0;
    bitInc   = 1'b0;
    stb      = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stateNxt  = ST_ENT_HOLD;
          tLoad     = 1'b1;
          tVal      = HOLD_LD;
          stb.clear = 1'b1;
        end
      end
      ST_ENT_HOLD: begin
        if (tZero) begin
          stateNxt = ST_ENT_GAP;
          tLoad    = 1'b1;
          tVal     = GAP_LD;
        end
      end
      ST_ENT_GAP: begin
        if (tZero) begin
          stateNxt     = ST_TX_HI;
          tLoad        = 1'b1;
          tVal         = HALF_LD;
          bitClr       = 1'b1;
          stb.loadWord = 1'b1;
        end
      end
      ST_TX_HI: begin
        if (tZero) begin
          stateNxt = ST_TX_LO;
          tLoad    = 1'b1;
          tVal     = HALF_LD;
        end
      end
      ST_TX_LO: begin
        if (tZero) begin
          tLoad = 1'b1;
          if (bitCnt == LAST_BIT) begin
            stateNxt = ST_WR_WAIT;
            tVal     = WRITE_LD;
          end else begin
            stateNxt     = ST_TX_HI;
            tVal         = HALF_LD;
            bitInc       = 1'b1;
            stb.shiftBit = 1'b1;
          end
        end
      end
      ST_WR_WAIT: begin
        if (tZero) begin
          stateNxt = ST_ACK_POLL;
          tLoad    = 1'b1;
          tVal     = ACK_LD;
        end
      end
      ST_ACK_POLL: begin
        if (ackIn) begin
          tLoad = 1'b1;
          tVal  = HALF_LD;
          if (lastWord) begin
            stateNxt = ST_VF_HI;
          end else begin
            stateNxt     = ST_TX_HI;
            bitClr       = 1'b1;
            stb.loadWord = 1'b1;
            stb.advWord  = 1'b1;
          end
        end else if (tZero) begin
          stateNxt      = ST_IDLE;
          stb.setAckErr = 1'b1;
        end
      end
      ST_VF_HI: begin
        if (tZero) begin
          stateNxt      = ST_VF_LO;
          tLoad         = 1'b1;
          tVal          = HALF_LD;
          stb.sampleBit = 1'b1;
        end
      end
      ST_VF_LO: begin
        if (tZero) begin
          if (lastBit) begin
            stateNxt    = ST_IDLE;
            stb.setDone = 1'b1;
          end else begin
            stateNxt = ST_VF_HI;
            tLoad    = 1'b1;
            tVal     = HALF_LD;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    progClk  = 1'b0;
    dataOe   = 1'b0;
    lineMode = LINE_LOW;
    case (state)
      ST_ENT_HOLD: begin progClk = 1'b1; dataOe = 1'b1; lineMode = LINE_LOW;  end
      ST_ENT_GAP:  begin progClk = 1'b1; dataOe = 1'b1; lineMode = LINE_HIGH; end
      ST_TX_HI:    begin progClk = 1'b1; dataOe = 1'b1; lineMode = LINE_BIT;  end
      ST_TX_LO:    begin                 dataOe = 1'b1; lineMode = LINE_BIT;  end
      ST_VF_HI:    begin progClk = 1'b1; end
      default:     begin end
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cfg_prog_dpath.sv
module cfg_prog_dpath
  import cfg_prog_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 12
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  seqStrobe_t                          stb,
  input  lineMode_e                           lineMode,
  input  logic                                dataOe,
  input  logic [WORD_W*N_WORDS-1:0]           image,
  input  logic                                dataIn,
  output logic                                dataOut,
  output logic                                lastWord,
  output logic                                lastBit,
  output logic                                done,
  output logic                                ackErr,
  output logic                                verifyErr,
  output logic [$clog2(WORD_W*N_WORDS)-1:0]   mismatchIdx
);

  localparam int IMG_W = WORD_W * N_WORDS;
  localparam int IDX_W = $clog2(IMG_W);
  localparam int VC_W  = $clog2(IMG_W + 1);
  localparam int WI_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [IMG_W-1:0]    imgReg;
  logic [2*WORD_W-1:0] txReg;
  logic [WI_W-1:0]     wordIdx, wordSel;
  logic [VC_W-1:0]     vIdx;
  logic [WORD_W-1:0]   selWord;

  assign wordSel = stb.advWord ? wordIdx + 1'b1 : wordIdx;
  assign selWord = imgReg[wordSel*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imgReg      <= '0;
      txReg       <= '0;
      wordIdx     <= '0;
      vIdx        <= '0;
      done        <= 1'b0;
      ackErr      <= 1'b0;
      verifyErr   <= 1'b0;
      mismatchIdx <= '0;
    end else begin
      if (stb.clear) begin
        imgReg      <= image;
        wordIdx     <= '0;
        vIdx        <= '0;
        done        <= 1'b0;
        ackErr      <= 1'b0;
        verifyErr   <= 1'b0;
        mismatchIdx <= '0;
      end
      if (stb.loadWord) begin
        txReg   <= {~selWord, selWord};
        wordIdx <= wordSel;
      end else if (stb.shiftBit) begin
        txReg <= {1'b0, txReg[2*WORD_W-1:1]};
      end
      if (stb.sampleBit) begin
        vIdx <= vIdx + 1'b1;
        if (!verifyErr && (dataIn != imgReg[vIdx])) begin
          verifyErr   <= 1'b1;
          mismatchIdx <= vIdx[IDX_W-1:0];
        end
      end
      if (stb.setDone)   done   <= 1'b1;
      if (stb.setAckErr) ackErr <= 1'b1;
    end
  end

  always_comb begin
    dataOut = 1'b0;
    if (dataOe) begin
      case (lineMode)
        LINE_HIGH: dataOut = 1'b1;
        LINE_BIT:  dataOut = txReg[0];
        default:   dataOut = 1'b0;
      endcase
    end
  end

  assign lastWord = (wordIdx == WI_W'(N_WORDS - 1));
  assign lastBit  = (vIdx == VC_W'(IMG_W));

endmodule

// File: rtl/cfg_prog_master.sv
module cfg_prog_master
  import cfg_prog_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int N_WORDS    = 12,
  parameter int HOLD_CYC   = 20,
  parameter int GAP_CYC    = 4,
  parameter int HALF_CYC   = 3,
  parameter int WRITE_CYC  = 10,
  parameter int ACK_TO_CYC = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [WORD_W*N_WORDS-1:0]         image,
  input  logic                              dataIn,
  output logic                              progClk,
  output logic                              dataOut,
  output logic                              dataOe,
  output logic                              busy,
  output logic                              done,
  output logic                              ackErr,
  output logic                              verifyErr,
  output logic [$clog2(WORD_W*N_WORDS)-1:0] mismatchIdx
);

  seqStrobe_t stb;
  lineMode_e  lineMode;
  logic       lastWord, lastBit;

  cfg_prog_ctrl #(
    .WORD_W    (WORD_W),
    .HOLD_CYC  (HOLD_CYC),
    .GAP_CYC   (GAP_CYC),
    .HALF_CYC  (HALF_CYC),
    .WRITE_CYC (WRITE_CYC),
    .ACK_TO_CYC(ACK_TO_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ackIn   (dataIn),
    .lastWord(lastWord),
    .lastBit (lastBit),
    .progClk (progClk),
    .dataOe  (dataOe),
    .lineMode(lineMode),
    .busy    (busy),
    .stb     (stb)
  );

  cfg_prog_dpath #(
    .WORD_W (WORD_W),
    .N_WORDS(N_WORDS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .lineMode   (lineMode),
    .dataOe     (dataOe),
    .image      (image),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .lastWord   (lastWord),
    .lastBit    (lastBit),
    .done       (done),
    .ackErr     (ackErr),
    .verifyErr  (verifyErr),
    .mismatchIdx(mismatchIdx)
  );

endmodule

// File: rtl/cfg_prog_checker.sv
module cfg_prog_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             progClk,
  input logic             dataOut,
  input logic             dataOe,
  input logic             busy,
  input logic             done,
  input logic             ackErr,
  input logic             verifyErr,
  input logic [IDX_W-1:0] mismatchIdx
);

  a_r1_entry_level: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (progClk && dataOe && !dataOut));

  a_r4_low_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!progClk && !$past(progClk) && dataOe && $past(dataOe)) |-> $stable(dataOut));

  a_r5_release_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dataOe) && busy) |-> !progClk);

  a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackErr) |-> (!busy && !done && !dataOe && !progClk));

  a_r9_end_status: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done ^ ackErr));

  a_r8_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    !verifyErr |-> (mismatchIdx == '0));

  a_r8_idx_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (verifyErr && $past(verifyErr)) |-> $stable(mismatchIdx));

  a_r11_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!progClk && !dataOe));

endmodule

bind cfg_prog_master cfg_prog_checker #(
  .IDX_W($clog2(WORD_W*N_WORDS))
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .progClk    (progClk),
  .dataOut    (dataOut),
  .dataOe     (dataOe),
  .busy       (busy),
  .done       (done),
  .ackErr     (ackErr),
  .verifyErr  (verifyErr),
  .mismatchIdx(mismatchIdx)
);

// File: tb/sim_cfg_prog_master.sv
module sim_cfg_prog_master;

  localparam int WORD_W = 16;
  localparam int NW     = 12;
  localparam int IMG_W  = WORD_W * NW;
  localparam int HOLD   = 20;
  localparam int GAP    = 4;
  localparam int HALF   = 3;
  localparam int WRITE  = 10;
  localparam int ACKTO  = 16;
  localparam int LIM    = HALF + WRITE + ACKTO;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN, start, dataIn;
  logic [IMG_W-1:0] image;
  logic             progClk, dataOut, dataOe, busy, done, ackErr, verifyErr;
  logic [7:0]       mismatchIdx;

  cfg_prog_master u0 (
    .clk(clk), .rstN(rstN), .start(start), .image(image), .dataIn(dataIn),
    .progClk(progClk), .dataOut(dataOut), .dataOe(dataOe), .busy(busy),
    .done(done), .ackErr(ackErr), .verifyErr(verifyErr), .mismatchIdx(mismatchIdx)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // target model configuration
  int ackDelay [NW];
  int noAckWord = -1;
  int corA = -1;
  int corB = -1;
  int sessId = 0;
  int seenSess = 0;

  // target model state
  logic        prevClk, prevOe, prevDout;
  logic [31:0] rxSh;
  logic [15:0] mem [NW];
  int rxCnt, wordsRx, ackWait, holdCnt, holdLen, highCnt, lowCnt;
  int highBad, lowBad, dataBad, complBad, vRise;
  bit entered, firstHigh, firstRise;
  int lowRunArr [NW+1];
  bit lowRec [NW+1];

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      summary();
      $finish;
    end
    if (sessId != seenSess) begin
      seenSess = sessId;
      dataIn = 1'b0;
      rxCnt = 0; wordsRx = 0; ackWait = -1; holdCnt = 0; holdLen = 0;
      highCnt = 0; lowCnt = 0; highBad = 0; lowBad = 0; dataBad = 0;
      complBad = 0; vRise = 0; entered = 0; firstHigh = 1; firstRise = 0;
      for (int k = 0; k <= NW; k++) begin lowRunArr[k] = -1; lowRec[k] = 0; end
      for (int k = 0; k < NW; k++) mem[k] = 'x;
      prevClk = progClk; prevOe = dataOe; prevDout = dataOut;
    end else if (rstN) begin
      // entry measurement
      if (!entered) begin
        if (progClk && dataOe && !dataOut) holdCnt++;
        else if (progClk && dataOe && dataOut && holdCnt > 0) begin
          entered = 1; holdLen = holdCnt;
        end
      end
      // acknowledge countdown
      if (ackWait > 0) begin
        ackWait--;
        if (ackWait == 0) begin dataIn = 1'b1; ackWait = -1; end
      end
      if (progClk && !prevClk) begin
        // rising edge
        if (firstRise && lowCnt < HALF) lowBad++;
        if (wordsRx >= 1 && !lowRec[wordsRx]) begin
          lowRunArr[wordsRx] = lowCnt; lowRec[wordsRx] = 1;
        end
        firstRise = 1;
        highCnt = 1;
        dataIn = 1'b0;
        if (wordsRx == NW && !dataOe) begin
          int vi;
          logic b;
          vi = vRise;
          b = mem[vi / WORD_W][vi % WORD_W];
          if (vi == corA || vi == corB) b = ~b;
          dataIn = b;
          vRise++;
        end
      end else if (progClk) begin
        highCnt++;
      end else if (prevClk) begin
        // falling edge
        if (!firstHigh && highCnt != HALF) highBad++;
        firstHigh = 0;
        lowCnt = 1;
        if (dataOe && wordsRx < NW) begin
          rxSh[rxCnt] = dataOut;
          rxCnt++;
          if (rxCnt == 2 * WORD_W) begin
            mem[wordsRx] = rxSh[15:0];
            if (rxSh[31:16] != ~rxSh[15:0]) complBad++;
            if (wordsRx != noAckWord) begin
              if (ackDelay[wordsRx] == 0) dataIn = 1'b1;
              else ackWait = ackDelay[wordsRx];
            end
            wordsRx++;
            rxCnt = 0;
          end
        end
      end else begin
        lowCnt++;
      end
      if (!progClk && !prevClk && dataOe && prevOe && dataOut != prevDout) dataBad++;
      prevClk = progClk; prevOe = dataOe; prevDout = dataOut;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int expLow(input int d);
    return ((d > HALF + WRITE) ? d : HALF + WRITE) + 1;
  endfunction

  function automatic int expAbort();
    for (int k = 0; k < NW; k++)
      if (k == noAckWord || ackDelay[k] >= LIM) return k;
    return -1;
  endfunction

  function automatic int expFirstMis();
    int m;
    m = -1;
    if (corA >= 0) m = corA;
    if (corB >= 0 && (m < 0 || corB < m)) m = corB;
    return m;
  endfunction

  function automatic logic [IMG_W-1:0] randImg();
    logic [IMG_W-1:0] v;
    for (int k = 0; k < IMG_W / 32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic randDelays();
    for (int k = 0; k < NW; k++) ackDelay[k] = $urandom_range(LIM - 1, 0);
  endtask

  task automatic zeroDelays();
    for (int k = 0; k < NW; k++) ackDelay[k] = 0;
  endtask

  task automatic runSession(input logic [IMG_W-1:0] img, input bit tryRestart);
    int ab, fm, n;
    @(negedge clk);
    image = img;
    sessId++;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9 busy after start", busy, 1);
    check(done === 1'b0 && ackErr === 1'b0 && verifyErr === 1'b0, "R9 status cleared by start",
          {done, ackErr, verifyErr}, 0);
    if (tryRestart) begin
      repeat (60) @(negedge clk);
      image = ~img;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(!busy, "R9 session ends", busy, 0);
    ab = expAbort();
    check(holdLen == HOLD, "R1 entry hold length", holdLen, HOLD);
    for (int w = 0; w < NW; w++)
      if (ab < 0 || w < ab)
        check(mem[w] === img[w*WORD_W +: WORD_W], $sformatf("R2/R10 word %0d", w),
              int'(mem[w]), int'(img[w*WORD_W +: WORD_W]));
    check(complBad == 0, "R3 complement words", complBad, 0);
    check(highBad == 0, "R4 high phase length", highBad, 0);
    check(lowBad == 0, "R4 low phase minimum", lowBad, 0);
    check(dataBad == 0, "R4 data held while clock low", dataBad, 0);
    if (ab < 0) begin
      check(done === 1'b1, "R9 done after full session", done, 1);
      check(ackErr === 1'b0, "R6 no abort", ackErr, 0);
      for (int k = 1; k < NW; k++)
        check(lowRunArr[k] == expLow(ackDelay[k-1]), $sformatf("R5 gap before word %0d", k),
              lowRunArr[k], expLow(ackDelay[k-1]));
      check(lowRunArr[NW] == expLow(ackDelay[NW-1]), "R7 gap before verify",
            lowRunArr[NW], expLow(ackDelay[NW-1]));
      check(vRise == IMG_W, "R7 verify pulse count", vRise, IMG_W);
      fm = expFirstMis();
      check(verifyErr === (fm >= 0), "R8 verify flag", verifyErr, fm >= 0);
      check(int'(mismatchIdx) == ((fm >= 0) ? fm : 0), "R8 first mismatch index",
            mismatchIdx, (fm >= 0) ? fm : 0);
    end else begin
      check(ackErr === 1'b1, "R6 ack timeout flag", ackErr, 1);
      check(done === 1'b0, "R6 no done on abort", done, 0);
      check(wordsRx == ab + 1, "R6 words sent before abort", wordsRx, ab + 1);
      check(!progClk && !dataOe, "R6 lines idle after abort", {progClk, dataOe}, 0);
      check(vRise == 0, "R6 no verify after abort", vRise, 0);
      check(verifyErr === 1'b0, "R6 no verify flag", verifyErr, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    rstN = 1'b0; start = 1'b0; image = '0;
    zeroDelays();
    repeat (4) @(negedge clk);
    // R11: reset state
    check({progClk, dataOe, dataOut, busy, done, ackErr, verifyErr} == 7'b0,
          "R11 reset outputs", {progClk, dataOe, dataOut, busy, done, ackErr, verifyErr}, 0);
    check(mismatchIdx == 8'd0, "R11 reset index", mismatchIdx, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: all zeros, immediate acks
    zeroDelays(); noAckWord = -1; corA = -1; corB = -1;
    runSession('0, 0);
    // all ones, corruption at first index
    corA = 0;
    runSession('1, 0);
    // random, last index corrupted
    randDelays(); corA = IMG_W - 1; corB = -1;
    runSession(randImg(), 0);
    // boundary ack delays and two corruptions
    randDelays(); ackDelay[0] = LIM - 1; ackDelay[NW-1] = LIM - 1; ackDelay[4] = HALF + WRITE;
    corA = 100; corB = 37;
    runSession(randImg(), 0);
    // R10: restart attempt while busy and image changed
    randDelays(); corA = -1; corB = -1;
    runSession(randImg(), 1);
    // R6: no ack on first word
    zeroDelays(); noAckWord = 0;
    runSession(randImg(), 0);
    // R6: ack one cycle too late on a middle word
    randDelays(); noAckWord = -1; ackDelay[5] = LIM;
    runSession(randImg(), 0);
    // R6: no ack on the last word
    randDelays(); noAckWord = NW - 1;
    runSession(randImg(), 0);
    // random sessions
    noAckWord = -1;
    for (int s = 0; s < 4; s++) begin
      randDelays();
      corA = ($urandom_range(1, 0) == 1) ? int'($urandom_range(IMG_W - 1, 0)) : -1;
      corB = ($urandom_range(1, 0) == 1) ? int'($urandom_range(IMG_W - 1, 0)) : -1;
      runSession(randImg(), 0);
    end
    summary();
    $finish;
  end

endmodule